// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a bank of eight byte-wide timekeeping registers placed at the top offsets of a byte-wide memory map. Inside it runs a packed-BCD calendar and time-of-day counter: seconds, minutes, 24-hour hours, weekday, date, month and two-digit year. The counter advances once for each cycle in which the one-per-second `tick` enable is high. The host never reads the counter directly. It reads a visible copy that follows the counter on every tick, so a read never sees a value that is partway through changing.

Two flags in the control byte freeze the visible copy. The hold-read flag freezes the copy while the counter keeps running; clearing it refreshes all the time fields together. The set-time flag stops the counter; clearing it copies the host-written visible time fields into the counter in one cycle. A stop flag in the seconds byte makes the counter ignore ticks. A test flag in the weekday byte makes `ftest_out` toggle on every tick. Bits with no function are plain storage. The bus is a plain register port with no back-pressure: a write completes in the cycle `wr_en` is high, and `rdata` is a combinational view of the addressed byte.

Top module: `rtc_regbank`

## Requirements
- R1: After reset the bytes read as follows: offset 0 (control) 0x00, 1 (seconds) 0x00, 2 (minutes) 0x00, 3 (hours) 0x00, 4 (weekday) 0x01, 5 (date) 0x01, 6 (month) 0x01, 7 (year) 0x00. `ftest_out` is 0.
- R2: Time fields are packed BCD. Seconds and minutes (bits 6:0) wrap from 0x59 to 0x00 and carry. Hours (bits 5:0) count 0x00 to 0x23 with a decimal carry from 0x09 to 0x10, and their wrap carries into date and weekday.
- R3: While control bit 6 (hold-read) or bit 7 (set-time) is 1 and no write occurs, no visible byte changes, even when ticks arrive.
- R4: A control write that leaves bits 7 and 6 at 0 while hold-read is 1 loads every visible time field from the running counter on that clock edge.
- R5: While set-time is 1 the counter does not advance. A control write that clears set-time loads the counter from the visible time fields in that cycle.
- R6: While seconds bit 7 (stop) is 1, ticks do not advance the count or the visible time.
- R7: While weekday bit 6 (test) is 1, `ftest_out` inverts on every tick. Otherwise it holds its value.
- R8: Every write stores the full byte. Bits outside the time fields (control bits 5:0, seconds bit 7, minutes bit 7, hours bits 7:6, weekday bits 7:3, date bits 7:6, month bits 7:5) keep their value across tick updates.
- R9: The date wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February. The month then advances.
- R10: February ends at 0x29 when the BCD year is divisible by four (0x00 included), and at 0x28 otherwise.
- R11: Weekday bits 2:0 wrap from 0x07 to 0x01. Month bits 4:0 wrap from 0x12 to 0x01 and advance the year. The year wraps from 0x99 to 0x00.
- R12: With both freeze flags at 0, a tick changes the visible time fields on the same edge as the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-per-second advance enable, one cycle wide |
| addr | input | AW (3) | Register offset for reads and writes |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Byte at `addr` (combinational) |
| ftest_out | output | 1 | Timebase test output |

## Verification
The bench drives the calendar across its carry chain: end of the century on New Year's Eve, 30- and 31-day month ends, February in leap and common years including year 00, and a 09-to-10 hour carry. A design with a binary instead of decimal increment, a wrong leap rule or a wrong month table would show a wrong date or month after the tick. The bench checks that a frozen copy does not move during ticks and that releasing hold-read exposes the advanced count. A design that refreshed late or only partly would show stale seconds. It also checks that time written under set-time becomes the count, and that spare and flag bits survive tick updates. A design that overwrote whole bytes from the counter would lose those bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 3;
  localparam int MAP_REGS = 8;

  // register offsets (rollover order depends on these)
  localparam int OFF_CTL  = 0;
  localparam int OFF_SEC  = 1;
  localparam int OFF_MIN  = 2;
  localparam int OFF_HOUR = 3;
  localparam int OFF_WDAY = 4;
  localparam int OFF_DATE = 5;
  localparam int OFF_MON  = 6;
  localparam int OFF_YEAR = 7;

  // flag bit positions
  localparam int CTL_SET_POS  = 7;
  localparam int CTL_HOLD_POS = 6;
  localparam int SEC_STOP_POS = 7;
  localparam int WDAY_TST_POS = 6;

  // bits of each byte that belong to the counted time field
  function automatic logic [7:0] field_mask(input int off);
    case (off)
      OFF_SEC, OFF_MIN:    return 8'h7F;
      OFF_HOUR, OFF_DATE:  return 8'h3F;
      OFF_WDAY:            return 8'h07;
      OFF_MON:             return 8'h1F;
      OFF_YEAR:            return 8'hFF;
      default:             return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int off);
    case (off)
      OFF_WDAY, OFF_DATE, OFF_MON: return 8'h01;
      default:                     return 8'h00;
    endcase
  endfunction

  // BCD year divisible by four
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int         W  = 8,
  parameter logic [W-1:0] LO = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic [W-1:0] nxt
);
  localparam int NIB = W / 4;

  logic [W-1:0] plus1;

  always_comb begin
    logic c;
    c     = 1'b1;
    plus1 = val;
    for (int k = 0; k < NIB; k++) begin
      if (c) begin
        if (val[4*k +: 4] == 4'd9) begin
          plus1[4*k +: 4] = 4'd0;
        end else begin
          plus1[4*k +: 4] = val[4*k +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (ld)       nxt = ld_val;
    else if (inc) nxt = clr ? LO : plus1;
    else          nxt = val;
  end

  always_ff @(posedge clk) begin
    if (rst) val <= LO;
    else     val <= nxt;
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv,
  input  logic                       ld,
  input  logic [(MAP_REGS-1)*DW-1:0] ld_flat,
  output logic [MAP_REGS*DW-1:0]     cnt_flat,
  output logic [MAP_REGS*DW-1:0]     nxt_flat
);
  logic [DW-1:0] se_v, mi_v, hr_v, wd_v, dt_v, mo_v, yr_v;
  logic [DW-1:0] se_n, mi_n, hr_n, wd_n, dt_n, mo_n, yr_n;
  logic [DW-1:0] dt_hi;
  logic se_top, mi_top, hr_top, wd_top, dt_top, mo_top, yr_top;
  logic se_c, mi_c, hr_c, dt_c, mo_c;

  assign dt_hi  = DW'(month_len(mo_v[7:0], yr_v[7:0]));

  assign se_top = se_v >= DW'(8'h59);
  assign mi_top = mi_v >= DW'(8'h59);
  assign hr_top = hr_v >= DW'(8'h23);
  assign wd_top = wd_v >= DW'(8'h07);
  assign dt_top = dt_v >= dt_hi;
  assign mo_top = mo_v >= DW'(8'h12);
  assign yr_top = yr_v >= DW'(8'h99);

  assign se_c = adv  && se_top;
  assign mi_c = se_c && mi_top;
  assign hr_c = mi_c && hr_top;
  assign dt_c = hr_c && dt_top;
  assign mo_c = dt_c && mo_top;

  rtc_bcd_field #(.W(DW), .LO(DW'(0))) u_sec (
    .clk(clk), .rst(rst), .inc(adv), .clr(se_top), .ld(ld),
    .ld_val(ld_flat[(OFF_SEC-1)*DW +: DW]), .val(se_v), .nxt(se_n));
  rtc_bcd_field #(.W(DW), .LO(DW'(0))) u_min (
    .clk(clk), .rst(rst), .inc(se_c), .clr(mi_top), .ld(ld),
    .ld_val(ld_flat[(OFF_MIN-1)*DW +: DW]), .val(mi_v), .nxt(mi_n));
  rtc_bcd_field #(.W(DW), .LO(DW'(0))) u_hour (
    .clk(clk), .rst(rst), .inc(mi_c), .clr(hr_top), .ld(ld),
    .ld_val(ld_flat[(OFF_HOUR-1)*DW +: DW]), .val(hr_v), .nxt(hr_n));
  rtc_bcd_field #(.W(DW), .LO(DW'(1))) u_wday (
    .clk(clk), .rst(rst), .inc(hr_c), .clr(wd_top), .ld(ld),
    .ld_val(ld_flat[(OFF_WDAY-1)*DW +: DW]), .val(wd_v), .nxt(wd_n));
  rtc_bcd_field #(.W(DW), .LO(DW'(1))) u_date (
    .clk(clk), .rst(rst), .inc(hr_c), .clr(dt_top), .ld(ld),
    .ld_val(ld_flat[(OFF_DATE-1)*DW +: DW]), .val(dt_v), .nxt(dt_n));
  rtc_bcd_field #(.W(DW), .LO(DW'(1))) u_mon (
    .clk(clk), .rst(rst), .inc(dt_c), .clr(mo_top), .ld(ld),
    .ld_val(ld_flat[(OFF_MON-1)*DW +: DW]), .val(mo_v), .nxt(mo_n));
  rtc_bcd_field #(.W(DW), .LO(DW'(0))) u_year (
    .clk(clk), .rst(rst), .inc(mo_c), .clr(yr_top), .ld(ld),
    .ld_val(ld_flat[(OFF_YEAR-1)*DW +: DW]), .val(yr_v), .nxt(yr_n));

  assign cnt_flat = {yr_v, mo_v, dt_v, wd_v, hr_v, mi_v, se_v, {DW{1'b0}}};
  assign nxt_flat = {yr_n, mo_n, dt_n, wd_n, hr_n, mi_n, se_n, {DW{1'b0}}};
endmodule

// File: rtl/rtc_ftest.sv
module rtc_ftest (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst)              tog <= 1'b0;
    else if (en && tick)  tog <= ~tog;
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ftest_out
);
  localparam int NREG = 1 << AW;

  logic [NREG*DW-1:0]         vis_flat;
  logic [MAP_REGS*DW-1:0]     cnt_flat;
  logic [MAP_REGS*DW-1:0]     nxt_flat;
  logic [(MAP_REGS-1)*DW-1:0] ld_flat;

  logic ctl_hit, w_bit, r_bit, osc_stop, ft_en;
  logic adv, w_release, refresh, upd;

  assign ctl_hit  = wr_en && (addr == AW'(OFF_CTL));
  assign w_bit    = vis_flat[OFF_CTL*DW + CTL_SET_POS];
  assign r_bit    = vis_flat[OFF_CTL*DW + CTL_HOLD_POS];
  assign osc_stop = vis_flat[OFF_SEC*DW + SEC_STOP_POS];
  assign ft_en    = vis_flat[OFF_WDAY*DW + WDAY_TST_POS];

  assign adv       = tick && !osc_stop && !w_bit;
  assign w_release = ctl_hit && w_bit && !wdata[CTL_SET_POS];
  assign refresh   = ctl_hit && r_bit && !w_bit &&
                     !wdata[CTL_SET_POS] && !wdata[CTL_HOLD_POS];
  assign upd       = (adv && !r_bit) || refresh;

  for (genvar o = 1; o < MAP_REGS; o++) begin : g_ld
    assign ld_flat[(o-1)*DW +: DW] = vis_flat[o*DW +: DW] & DW'(field_mask(o));
  end

  rtc_time_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .adv(adv), .ld(w_release),
    .ld_flat(ld_flat), .cnt_flat(cnt_flat), .nxt_flat(nxt_flat));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MSK = (i < MAP_REGS) ? DW'(field_mask(i)) : '0;
    localparam logic [DW-1:0] RST = DW'(field_reset(i));
    logic [DW-1:0] src;
    logic [DW-1:0] q;
    if (i < MAP_REGS) begin : g_src
      assign src = nxt_flat[i*DW +: DW];
    end else begin : g_nosrc
      assign src = '0;
    end
    always_ff @(posedge clk) begin
      if (rst)                              q <= RST;
      else if (wr_en && addr == AW'(i))     q <= wdata;
      else if (upd)                         q <= (q & ~MSK) | (src & MSK);
    end
    assign vis_flat[i*DW +: DW] = q;
  end

  assign rdata = vis_flat[addr*DW +: DW];

  rtc_ftest u_ftest (
    .clk(clk), .rst(rst), .tick(tick), .en(ft_en), .tog(ftest_out));
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
  import rtc_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = BYTE_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic [AW-1:0]            addr,
  input logic                     wr_en,
  input logic [DW-1:0]            wdata,
  input logic                     ftest_out,
  input logic [(1<<AW)*DW-1:0]    vis_flat,
  input logic [MAP_REGS*DW-1:0]   cnt_flat,
  input logic                     r_bit,
  input logic                     w_bit,
  input logic                     osc_stop,
  input logic                     ft_en
);
  logic          lw_v;
  logic [AW-1:0] lw_a;
  logic [DW-1:0] lw_d;
  logic          ctl_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_v <= 1'b0;
      lw_a <= '0;
      lw_d <= '0;
    end else begin
      lw_v <= wr_en;
      lw_a <= addr;
      lw_d <= wdata;
    end
  end

  assign ctl_wr = wr_en && (addr == AW'(OFF_CTL));

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    lw_v |-> (vis_flat[lw_a*DW +: DW] == lw_d)); // R8

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((r_bit || w_bit) && !wr_en) |=> $stable(vis_flat)); // R3

  AST_HOLD_REFRESH: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && r_bit && !w_bit && !wdata[CTL_SET_POS] && !wdata[CTL_HOLD_POS])
    |=> (vis_flat[OFF_SEC*DW +: 7] == cnt_flat[OFF_SEC*DW +: 7])); // R4

  AST_SET_HALTS: assert property (@(posedge clk) disable iff (rst)
    (w_bit && !(ctl_wr && !wdata[CTL_SET_POS])) |=> $stable(cnt_flat)); // R5

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && !w_bit) |=> $stable(cnt_flat)); // R6

  AST_FT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (ft_en && tick) |=> (ftest_out != $past(ftest_out))); // R7

  AST_FT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(ft_en && tick) |=> $stable(ftest_out)); // R7
endmodule

bind rtc_regbank rtc_regbank_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .ftest_out(ftest_out), .vis_flat(vis_flat),
  .cnt_flat(cnt_flat), .r_bit(r_bit), .w_bit(w_bit),
  .osc_stop(osc_stop), .ft_en(ft_en));

// File: tb/tb_rtc_regbank.sv
`timescale 1ns/1ps
module tb_rtc_regbank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ftest_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] a;
    logic [7:0] e;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  rtc_regbank dut (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ftest_out(ftest_out));

  // monitor: pops expected reads and compares after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        n_chk++;
        if (rdata !== it.e) begin
          n_bad++;
          $display("FAIL %s off=%0d got=%02h exp=%02h", it.tag, it.a, rdata, it.e);
        end
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a;
    sb.push_back('{a, e, tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_ft(input logic e, input string tag);
    @(negedge clk);
    n_chk++;
    if (ftest_out !== e) begin
      n_bad++;
      $display("FAIL %s ftest_out got=%0b exp=%0b", tag, ftest_out, e);
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, wd, h, mi, s);
    wr(0, 8'h80);
    wr(7, y); wr(6, mo); wr(5, d); wr(4, wd);
    wr(3, h); wr(2, mi); wr(1, s);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 8'h00, "R1 ctl");  rd(1, 8'h00, "R1 sec");
    rd(2, 8'h00, "R1 min");  rd(3, 8'h00, "R1 hour");
    rd(4, 8'h01, "R1 wday"); rd(5, 8'h01, "R1 date");
    rd(6, 8'h01, "R1 mon");  rd(7, 8'h00, "R1 year");
    chk_ft(1'b0, "R1 ftest");

    // R5 load, R12 follow, R2/R11 full rollover
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    tk(1);
    rd(1, 8'h59, "R12 sec follows tick (R5 loaded)");
    tk(1);
    rd(1, 8'h00, "R2 sec wrap");  rd(2, 8'h00, "R2 min wrap");
    rd(3, 8'h00, "R2 hour wrap"); rd(4, 8'h01, "R11 wday wrap");
    rd(5, 8'h01, "R9 date wrap"); rd(6, 8'h01, "R11 month wrap");
    rd(7, 8'h00, "R11 year wrap");

    // R5 set-time holds visible, release loads count
    wr(0, 8'h80); wr(1, 8'h30); tk(2);
    rd(1, 8'h30, "R5 visible held under set");
    wr(0, 8'h00); tk(1);
    rd(1, 8'h31, "R5 count from written value");

    // R3 freeze, R4 refresh
    wr(0, 8'h40); tk(4);
    rd(1, 8'h31, "R3 frozen sec");
    rd(0, 8'h40, "R3 ctl readback");
    wr(0, 8'h00);
    rd(1, 8'h35, "R4 refreshed sec");

    // R6 oscillator stop
    wr(1, 8'hB5); tk(3);
    rd(1, 8'hB5, "R6 stopped");
    wr(1, 8'h35); tk(1);
    rd(1, 8'h36, "R6 resumed");

    // R7 test output, R8 spare bits across tick
    wr(4, 8'hC1); tk(1);
    chk_ft(1'b1, "R7 toggle 1");
    rd(4, 8'hC1, "R8 wday flag+spare kept");
    tk(1);
    chk_ft(1'b0, "R7 toggle 2");
    tk(1);
    chk_ft(1'b1, "R7 toggle 3");
    wr(4, 8'h01); tk(1);
    chk_ft(1'b1, "R7 quiet when off");

    // R8 storage
    wr(0, 8'h3F);
    rd(0, 8'h3F, "R8 ctl spare");
    wr(0, 8'h00);
    wr(2, 8'hA5);
    rd(2, 8'hA5, "R8 min full byte");
    tk(1);
    rd(2, 8'h80, "R8 min spare kept, field from count");
    wr(2, 8'h00);

    // R2 decimal hour carry
    set_time(8'h21, 8'h01, 8'h01, 8'h05, 8'h09, 8'h59, 8'h59); tk(1);
    rd(3, 8'h10, "R2 hour 09->10");
    rd(2, 8'h00, "R2 min after carry");

    // R9 month lengths
    set_time(8'h21, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h01, "R9 april end date"); rd(6, 8'h05, "R9 april end month");
    rd(4, 8'h04, "R11 wday advance");
    set_time(8'h21, 8'h05, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h31, "R9 may 31st exists"); rd(6, 8'h05, "R9 may stays");
    set_time(8'h21, 8'h05, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h01, "R9 may end date"); rd(6, 8'h06, "R9 may end month");

    // R10 February
    set_time(8'h21, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h01, "R10 common feb date"); rd(6, 8'h03, "R10 common feb month");
    set_time(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h29, "R10 leap feb 29"); rd(6, 8'h02, "R10 leap feb month");
    set_time(8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h01, "R10 leap feb end"); rd(6, 8'h03, "R10 leap march");
    set_time(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h29, "R10 year 00 leap");
    set_time(8'h98, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk(1);
    rd(5, 8'h01, "R10 year 98 common");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule